// File: doc/BRIEF.md
# Mixed-Sign Indexed Byte Dot-Product Accumulator

This block is one stage of a vector datapath. Each 32-bit result lane adds four 8x8 products to its own accumulator lane. The first byte source is read per lane. The second source is not read per lane. Inside every 128-bit segment, a 2-bit index picks one 32-bit group of that segment, and that group feeds all the lanes of the segment.

The products are mixed-sign: exactly one of the two factors is signed. An operation selector, taken from bits [15:10] of the issuing instruction word, chooses which factor that is. The caller also supplies an active vector length in bytes. Lanes beyond that length return zero.

The block accepts one operation per cycle when `in_valid` is high and registers the result. `done` pulses one cycle later. An operation is rejected, with `illegal` raised and the result left as it was, when the 8-bit integer matrix feature enable is clear or when the selector is not one of the two mixed-sign codes.

Top module: `mixdot_unit`

## Requirements
- R1: For each active lane i, the result equals accumulator lane i plus the sum over k = 0..3 of first-source byte 4i+k times indexed byte k, taken modulo 2^32 with no saturation.
- R2: Selector 6'b000111 treats the first-source bytes as signed (two's complement) and the indexed bytes as unsigned.
- R3: Selector 6'b000110 treats the first-source bytes as unsigned and the indexed bytes as signed.
- R4: Indexed byte k for a lane in segment s is byte 16*s + 4*idx + k of the second source, where idx is 0..3. Each segment makes this choice independently.
- R5: An active length of 8 bytes gives two active lanes. Those lanes still use the group that idx selects, even when that group lies beyond byte 7.
- R6: Result lanes whose bytes 4i..4i+3 are not all below the active length (bytes 16 and 32 are the other legal lengths) are zero.
- R7: When `feat_en` is low, an accepted operation raises `illegal` and leaves `res` unchanged.
- R8: Any selector value other than the two in R2 and R3 raises `illegal` and leaves `res` unchanged.
- R9: `done` is high exactly in the cycle after each cycle with `in_valid` high, and `illegal` is high only together with `done`. Synchronous reset clears `res`, `done` and `illegal` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| feat_en | input | 1 | 8-bit integer matrix feature enable |
| op_sel | input | 6 | Operation selector (instruction bits [15:10]) |
| idx | input | 2 | Group index within each 128-bit segment |
| vlen_bytes | input | 6 | Active vector length in bytes (8, 16 or 32) |
| src_n | input | 256 | Per-lane byte source |
| src_m | input | 256 | Indexed byte source |
| acc | input | 256 | Accumulator vector, eight 32-bit lanes |
| res | output | 256 | Registered result vector |
| done | output | 1 | Result valid, one cycle after `in_valid` |
| illegal | output | 1 | Operation was rejected |

## Verification
Tail zeroing and indexed broadcast meet in the same operation when the active length is 8 bytes and idx is 2 or 3. The selected group then lies entirely in the inactive upper half of the only segment. The bench drives that case with distinct values in every byte of the second source. It expects lanes 0 and 1 to carry products with bytes 8..15 and every higher lane to be zero. A rejected operation placed back-to-back with legal ones is judged by whether the previous result survives unchanged.

// File: rtl/mixdot_pkg.sv
package mixdot_pkg;

    localparam logic [5:0] OPC_UNS_BY_SGN = 6'b000110;
    localparam logic [5:0] OPC_SGN_BY_UNS = 6'b000111;

    typedef struct packed {
        logic legal;
        logic first_signed;
    } dec_t;

    typedef enum logic [1:0] {
        OPK_UNS_BY_SGN = 2'd0,
        OPK_SGN_BY_UNS = 2'd1,
        OPK_REJECT     = 2'd2
    } opk_e;

    // 9-bit-extended product of two bytes with independent signedness
    function automatic logic signed [17:0] mul_ext(
        input logic [7:0] a, input logic a_sgn,
        input logic [7:0] b, input logic b_sgn);
        logic signed [8:0] ax;
        logic signed [8:0] bx;
        ax = {a_sgn & a[7], a};
        bx = {b_sgn & b[7], b};
        return ax * bx;
    endfunction

endpackage

// File: rtl/mixdot_decode.sv
module mixdot_decode
    import mixdot_pkg::*;
(
    input  logic [5:0] op_sel,
    input  logic       feat_en,
    output dec_t       dec
);
    opk_e kind;

    always_comb begin
        unique case (op_sel)
            OPC_UNS_BY_SGN: kind = OPK_UNS_BY_SGN;
            OPC_SGN_BY_UNS: kind = OPK_SGN_BY_UNS;
            default:        kind = OPK_REJECT;
        endcase
    end

    always_comb begin
        dec.legal        = feat_en && (kind != OPK_REJECT);
        dec.first_signed = (kind == OPK_SGN_BY_UNS);
    end
endmodule

// File: rtl/mixdot_bcast.sv
module mixdot_bcast #(
    parameter int MAX_BYTES = 32,
    localparam int VW   = MAX_BYTES * 8,
    localparam int SEGS = MAX_BYTES / 16
) (
    input  logic [VW-1:0]            src_m,
    input  logic [1:0]               idx,
    output logic [SEGS-1:0][31:0]    grp
);
    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        logic [3:0][31:0] words;
        assign words = src_m[s*128 +: 128];
        assign grp[s] = words[idx];
    end
endmodule

// File: rtl/mixdot_lane.sv
module mixdot_lane
    import mixdot_pkg::*;
(
    input  logic [31:0] n_word,
    input  logic [31:0] m_word,
    input  logic [31:0] acc_word,
    input  logic        first_signed,
    input  logic        active,
    output logic [31:0] sum
);
    logic signed [17:0] prod [4];
    logic [31:0] total;

    always_comb begin
        total = acc_word;
        for (int k = 0; k < 4; k++) begin
            prod[k] = mul_ext(n_word[k*8 +: 8], first_signed,
                              m_word[k*8 +: 8], ~first_signed);
            total   = total + 32'(prod[k]);
        end
        sum = active ? total : 32'd0;
    end
endmodule

// File: rtl/mixdot_unit.sv
module mixdot_unit
    import mixdot_pkg::*;
#(
    parameter int MAX_BYTES = 32,
    localparam int VW    = MAX_BYTES * 8,
    localparam int LANES = MAX_BYTES / 4,
    localparam int SEGS  = MAX_BYTES / 16,
    localparam int LW    = $clog2(MAX_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          feat_en,
    input  logic [5:0]    op_sel,
    input  logic [1:0]    idx,
    input  logic [LW-1:0] vlen_bytes,
    input  logic [VW-1:0] src_n,
    input  logic [VW-1:0] src_m,
    input  logic [VW-1:0] acc,
    output logic [VW-1:0] res,
    output logic          done,
    output logic          illegal
);
    dec_t                 dec;
    logic [SEGS-1:0][31:0] grp;
    logic [VW-1:0]        nxt;

    mixdot_decode u_dec (
        .op_sel  (op_sel),
        .feat_en (feat_en),
        .dec     (dec)
    );

    mixdot_bcast #(.MAX_BYTES(MAX_BYTES)) u_bcast (
        .src_m (src_m),
        .idx   (idx),
        .grp   (grp)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic act;
        assign act = 32'(vlen_bytes) >= 32'((l + 1) * 4);
        mixdot_lane u_lane (
            .n_word       (src_n[l*32 +: 32]),
            .m_word       (grp[l/4]),
            .acc_word     (acc[l*32 +: 32]),
            .first_signed (dec.first_signed),
            .active       (act),
            .sum          (nxt[l*32 +: 32])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res     <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= in_valid;
            illegal <= in_valid && !dec.legal;
            if (in_valid && dec.legal)
                res <= nxt;
        end
    end
endmodule

// File: rtl/mixdot_chk.sv
module mixdot_chk #(
    parameter int MAX_BYTES = 32,
    localparam int VW = MAX_BYTES * 8,
    localparam int LW = $clog2(MAX_BYTES + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          feat_en,
    input logic [5:0]    op_sel,
    input logic [LW-1:0] vlen_bytes,
    input logic [VW-1:0] res,
    input logic          done,
    input logic          illegal
);
    logic op_ok;
    assign op_ok = (op_sel == 6'b000110) || (op_sel == 6'b000111);

    // R9
    done_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> done);

    // R9
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !done);

    // R9
    illegal_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> done);

    // R7
    feat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !feat_en) |=> (illegal && $stable(res)));

    // R8
    badop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_ok) |=> (illegal && $stable(res)));

    // R6
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && feat_en && op_ok && vlen_bytes == LW'(8))
        |=> (res[VW-1:64] == '0));
endmodule

bind mixdot_unit mixdot_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .feat_en    (feat_en),
    .op_sel     (op_sel),
    .vlen_bytes (vlen_bytes),
    .res        (res),
    .done       (done),
    .illegal    (illegal)
);

// File: tb/mixdot_unit_tb.sv
module mixdot_unit_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         feat_en;
    logic [5:0]   op_sel;
    logic [1:0]   idx;
    logic [5:0]   vlen_bytes;
    logic [255:0] src_n, src_m, acc;
    logic [255:0] res;
    logic         done, illegal;

    always #10 clk = ~clk;

    mixdot_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .feat_en(feat_en),
        .op_sel(op_sel), .idx(idx), .vlen_bytes(vlen_bytes),
        .src_n(src_n), .src_m(src_m), .acc(acc),
        .res(res), .done(done), .illegal(illegal)
    );

    typedef struct {
        logic [255:0] r;
        logic         ill;
        string        tag;
    } item_t;

    item_t        sb[$];
    logic [255:0] last_res;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           finished = 0;

    function automatic logic [255:0] model(
        input logic [255:0] n, input logic [255:0] m, input logic [255:0] a,
        input bit first_sgn, input int ix, input int vl);
        logic [255:0] r;
        r = '0;
        for (int l = 0; l < 8; l++) begin
            logic [31:0] s;
            s = a[l*32 +: 32];
            for (int k = 0; k < 4; k++) begin
                logic [7:0] nb, mb;
                int x, y;
                nb = n[(4*l + k)*8 +: 8];
                mb = m[((l/4)*16 + ix*4 + k)*8 +: 8];
                if (first_sgn) begin x = $signed(nb); y = {24'd0, mb}; end
                else           begin x = {24'd0, nb}; y = $signed(mb); end
                s = s + 32'(x * y);
            end
            if ((l + 1) * 4 <= vl) r[l*32 +: 32] = s;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [255:0] got, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // driver: present one operation at a falling edge and queue its expectation
    task automatic drive(input logic [255:0] n, input logic [255:0] m,
                         input logic [255:0] a, input logic [5:0] op,
                         input int ix, input int vl, input bit fe,
                         input string tag);
        item_t it;
        bit legal;
        @(negedge clk);
        src_n = n; src_m = m; acc = a; op_sel = op;
        idx = 2'(ix); vlen_bytes = 6'(vl); feat_en = fe; in_valid = 1'b1;
        legal = fe && (op == 6'b000110 || op == 6'b000111);
        if (legal) last_res = model(n, m, a, op == 6'b000111, ix, vl);
        it.r = last_res; it.ill = !legal; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int cyc);
        for (int c = 0; c < cyc; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [255:0] ramp();
        logic [255:0] v;
        for (int b = 0; b < 32; b++) v[b*8 +: 8] = 8'(8'h80 + b * 7);
        return v;
    endfunction

    // monitor: compare each completed result against the head of the queue
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9 done without request", {255'd0, done}, '0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(res == it.r, it.tag, res, it.r);
                check(illegal == it.ill, {it.tag, " illegal flag"},
                      {255'd0, illegal}, {255'd0, it.ill});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; feat_en = 1'b0; op_sel = '0; idx = '0;
        vlen_bytes = '0; src_n = '0; src_m = '0; acc = '0; last_res = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(res == '0, "R9 reset res", res, '0);
        check(!done && !illegal, "R9 reset flags", {254'd0, done, illegal}, '0);

        // R2 all-ones first source as -1, unit indexed bytes
        drive({32{8'hFF}}, {32{8'h01}}, '0, 6'b000111, 0, 32, 1, "R2 signed-first -1*1");
        // R3 same bytes, now 255*1
        drive({32{8'hFF}}, {32{8'h01}}, '0, 6'b000110, 0, 32, 1, "R3 unsigned-first 255*1");
        // R3 indexed 0x80 read as -128
        drive({32{8'hFF}}, {32{8'h80}}, {8{32'd5}}, 6'b000110, 1, 32, 1, "R3 indexed signed -128");
        // R1 wraparound modulo 2^32
        drive({32{8'h7F}}, {32{8'hFF}}, {8{32'hFFFF_FFF0}}, 6'b000111, 2, 32, 1, "R1 wrap");
        // R4 each index with a distinct-byte second source
        for (int i = 0; i < 4; i++)
            drive(rnd256(), ramp(), rnd256(), 6'b000111, i, 32, 1, "R4 index select");
        // R5/R6 short length, group beyond active bytes
        drive(rnd256(), ramp(), rnd256(), 6'b000110, 3, 8, 1, "R5 vlen8 idx3");
        drive(rnd256(), ramp(), rnd256(), 6'b000111, 2, 8, 1, "R5 vlen8 idx2");
        drive(rnd256(), rnd256(), rnd256(), 6'b000110, 1, 16, 1, "R6 vlen16 tail zero");
        // R7 feature disabled, back-to-back with legal ops
        drive(rnd256(), rnd256(), rnd256(), 6'b000110, 0, 32, 0, "R7 feat off holds res");
        drive(rnd256(), rnd256(), rnd256(), 6'b000111, 1, 32, 0, "R7 feat off again");
        drive(rnd256(), rnd256(), rnd256(), 6'b000111, 3, 32, 1, "R1 legal after reject");
        // R8 other selector codes
        drive(rnd256(), rnd256(), rnd256(), 6'b000101, 0, 32, 1, "R8 bad selector");
        drive(rnd256(), rnd256(), rnd256(), 6'b100111, 2, 32, 1, "R8 bad selector high bit");
        idle(3);
        // R9 done is a single-cycle pulse
        check(!done && !illegal, "R9 idle flags", {254'd0, done, illegal}, '0);

        // R1/R2/R3/R4/R6 random sweep over modes, indices and lengths
        for (int t = 0; t < 60; t++) begin
            int vl;
            int sel;
            sel = $urandom_range(0, 2);
            vl = (sel == 0) ? 8 : (sel == 1) ? 16 : 32;
            drive(rnd256(), rnd256(), rnd256(),
                  ($urandom_range(0, 1) != 0) ? 6'b000111 : 6'b000110,
                  t % 4, vl, ($urandom_range(0, 7) != 0), "R1 random sweep");
            if (t % 5 == 0) idle(1);
        end
        idle(4);
        check(sb.size() == 0, "R9 all results seen", 256'(sb.size()), '0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule